// File: doc/BRIEF.md
# Guest Translation Buffer Flush Walker

This block holds the valid bits and guest identifiers of a small guest translation buffer and, on command, walks a range of entries and clears the ones that qualify. The buffer has two regions. The first is a variable region of `VSIZE` entries. The second is a fixed region of `FSETS` sets, each `WAYS` entries wide.

The flush range is chosen from three inputs: the MMU organisation code, the invalidate-walk mode and a command index. The range can be the whole buffer, the whole variable region, or one fixed-region set. A guest-ID filter can narrow the range further. Translation addresses and address-space IDs take no part in entry selection.

A fill port loads entries. The `valid_map` output exposes every valid bit. The walk visits one entry per clock while `busy` is high, and a one-cycle `done` pulse marks the end. A command that cannot run does not walk. Instead, `done` pulses one cycle after `start`, together with one exception flag.

Top module: `tlb_flush_walker`

## Requirements
- R1: After reset, every `valid_map` bit is 0, and `busy`, `done`, `exc_cpu`, `exc_ri` and `idx_err` are 0.
- R2: When `fill_en` is 1 at a clock edge and `fill_idx` < NTOT (NTOT = VSIZE + FSETS*WAYS), entry `fill_idx` takes `fill_valid` and `fill_gid`. A valid bit never rises except through a fill.
- R3: With `cmd_mmu_type` = 1 (joint array), all NTOT entries are walked and `cmd_index` has no effect.
- R4: With `cmd_mmu_type` = 4 and `cmd_walk_mode` = 2, an index below VSIZE walks entries 0 to VSIZE-1 only.
- R5: With type 4 and mode 2, an index in VSIZE to NTOT-1 walks only set k = (index-VSIZE)/WAYS. Set k covers entries VSIZE+k*WAYS to VSIZE+k*WAYS+WAYS-1.
- R6: With type 4 and mode 3, all NTOT entries are walked and the index has no effect.
- R7: When `cmd_gid_en` = 1, a walked entry is cleared only if its stored guest ID equals `cmd_root_gid`. When `cmd_gid_en` = 0, every walked entry is cleared.
- R8: If `cmd_cp_en` = 0 on a valid configuration, `exc_cpu` pulses with `done` and no entry changes.
- R9: A type other than 1 or 4, or type 4 with a mode other than 2 or 3, raises `exc_ri` with `done` and performs no walk. This case takes priority over R8.
- R10: With type 4 and mode 2, an index >= NTOT raises `idx_err` with `done` and changes nothing.
- R11: A walk holds `busy` high for exactly as many cycles as there are entries in its range. `done` is then high for one cycle with `busy` low. A command that does not walk pulses `done` in the cycle after `start`.
- R12: A `start` that arrives while `busy` is high is ignored.
- R13: Fill and walk can hit the same entry in the same cycle. If the entry qualifies, the clear wins. A fill to an entry that the walk has already passed persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDXW | Entry to write |
| fill_valid | input | 1 | Valid bit to write |
| fill_gid | input | GIDW | Guest ID to write |
| start | input | 1 | Flush request, taken when idle |
| cmd_index | input | IDXW | Flush index |
| cmd_mmu_type | input | 3 | Organisation code (1 joint, 4 split) |
| cmd_walk_mode | input | 2 | Walk mode (2 software, 3 hardware) |
| cmd_gid_en | input | 1 | Enable guest-ID filter |
| cmd_root_gid | input | GIDW | Guest ID to match |
| cmd_cp_en | input | 1 | Coprocessor access enabled |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_cpu | output | 1 | Coprocessor-unusable exception |
| exc_ri | output | 1 | Reserved-instruction exception |
| idx_err | output | 1 | Index out of range |
| valid_map | output | NTOT | Valid bit of every entry |

## Verification
The fill port and the walker's clear can address the same entry on the same clock edge. To provoke this, the bench writes entry 0 during a full hardware-mode walk, once in the first busy cycle and once in the second. In the first run, entry 0 is being examined, so the bench expects it cleared. In the second run, the walker has already passed entry 0, so the bench expects it valid. A second collision is a new `start` raised during a walk. The bench judges it by the busy-cycle count and by the fixed-region entries, which the second command would have cleared.

// File: rtl/tlb_flush_walker.sv
module tlb_flush_walker #(
  parameter int VSIZE = 16,
  parameter int FSETS = 8,
  parameter int WAYS  = 4,
  parameter int GIDW  = 8,
  localparam int NTOT = VSIZE + FSETS * WAYS,
  localparam int IDXW = $clog2(NTOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  logic            fill_valid,
  input  logic [GIDW-1:0] fill_gid,
  input  logic            start,
  input  logic [IDXW-1:0] cmd_index,
  input  logic [2:0]      cmd_mmu_type,
  input  logic [1:0]      cmd_walk_mode,
  input  logic            cmd_gid_en,
  input  logic [GIDW-1:0] cmd_root_gid,
  input  logic            cmd_cp_en,
  output logic            busy,
  output logic            done,
  output logic            exc_cpu,
  output logic            exc_ri,
  output logic            idx_err,
  output logic [NTOT-1:0] valid_map
);

  logic [NTOT-1:0] vld;
  logic [GIDW-1:0] gid [NTOT];
  logic [IDXW-1:0] ptr, endp, lo, hi;
  logic            g_en;
  logic [GIDW-1:0] r_gid;
  logic            bad_ri, bad_cpu, bad_idx, sw_split;

  assign valid_map = vld;
  assign sw_split  = (cmd_mmu_type == 3'd4) && (cmd_walk_mode == 2'd2);
  assign bad_ri    = !((cmd_mmu_type == 3'd1) ||
                       ((cmd_mmu_type == 3'd4) && ((cmd_walk_mode == 2'd2) || (cmd_walk_mode == 2'd3))));
  assign bad_cpu   = !bad_ri && !cmd_cp_en;
  assign bad_idx   = !bad_ri && !bad_cpu && sw_split && (int'(cmd_index) >= NTOT);

  always_comb begin
    lo = '0;
    hi = IDXW'(NTOT - 1);
    if (sw_split) begin
      if (int'(cmd_index) < VSIZE) begin
        hi = IDXW'(VSIZE - 1);
      end else begin
        lo = IDXW'(VSIZE + ((int'(cmd_index) - VSIZE) / WAYS) * WAYS);
        hi = IDXW'(VSIZE + ((int'(cmd_index) - VSIZE) / WAYS) * WAYS + WAYS - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= '0;
      for (int i = 0; i < NTOT; i++) gid[i] <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      exc_cpu <= 1'b0;
      exc_ri  <= 1'b0;
      idx_err <= 1'b0;
      ptr     <= '0;
      endp    <= '0;
      g_en    <= 1'b0;
      r_gid   <= '0;
    end else begin
      done    <= 1'b0;
      exc_cpu <= 1'b0;
      exc_ri  <= 1'b0;
      idx_err <= 1'b0;
      if (fill_en && (int'(fill_idx) < NTOT)) begin
        vld[fill_idx] <= fill_valid;
        gid[fill_idx] <= fill_gid;
      end
      if (busy) begin
        if (!g_en || (gid[ptr] == r_gid)) vld[ptr] <= 1'b0;
        if (ptr == endp) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else if (start) begin
        if (bad_ri || bad_cpu || bad_idx) begin
          done    <= 1'b1;
          exc_ri  <= bad_ri;
          exc_cpu <= bad_cpu;
          idx_err <= bad_idx;
        end else begin
          busy  <= 1'b1;
          ptr   <= lo;
          endp  <= hi;
          g_en  <= cmd_gid_en;
          r_gid <= cmd_root_gid;
        end
      end
    end
  end

endmodule

// File: rtl/tlb_flush_walker_chk.sv
module tlb_flush_walker_chk #(
  parameter int NTOT = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fill_en,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            exc_cpu,
  input logic            exc_ri,
  input logic            idx_err,
  input logic [NTOT-1:0] valid_map
);

  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_walk_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) || $past(start)));

  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_cpu, exc_ri, idx_err}));

  a_r8_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cpu || exc_ri || idx_err) |-> done);

  a_r8_no_change_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_cpu || exc_ri || idx_err) && !$past(fill_en)) |-> (valid_map == $past(valid_map)));

  a_r2_rise_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_map & ~$past(valid_map)) != '0) |-> $past(fill_en));

endmodule

bind tlb_flush_walker tlb_flush_walker_chk #(.NTOT(NTOT)) chk_i (.*);

// File: tb/tlb_flush_walker_tb.sv
module tlb_flush_walker_tb_top;
  localparam int VS = 16, FS = 8, WY = 4, GW = 8;
  localparam int NT = VS + FS * WY;
  localparam int IW = $clog2(NT + 1);

  logic clk = 0, rst_n = 0;
  logic fill_en = 0, fill_valid = 0, start = 0, cmd_gid_en = 0, cmd_cp_en = 1;
  logic [IW-1:0] fill_idx = '0, cmd_index = '0;
  logic [GW-1:0] fill_gid = '0, cmd_root_gid = '0;
  logic [2:0] cmd_mmu_type = 3'd1;
  logic [1:0] cmd_walk_mode = 2'd2;
  logic busy, done, exc_cpu, exc_ri, idx_err;
  logic [NT-1:0] valid_map;

  int tests = 0, fails = 0;
  bit ev [NT];
  logic [GW-1:0] eg [NT];

  always #10 clk = ~clk;

  tlb_flush_walker #(.VSIZE(VS), .FSETS(FS), .WAYS(WY), .GIDW(GW)) dut_i (.*);

  function automatic logic [NT-1:0] model_map();
    logic [NT-1:0] m;
    for (int i = 0; i < NT; i++) m[i] = ev[i];
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_all(int seed);
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      fill_en = 1; fill_idx = IW'(i); fill_valid = 1; fill_gid = GW'((i + seed) % 4);
      ev[i] = 1; eg[i] = GW'((i + seed) % 4);
    end
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic run_cmd(string req, int idx, int ty, int md, bit ge, int rg, bit cp,
                         int poke = 0, int coll = 0);
    bit x_ri, x_cpu, x_ie, walk;
    int lo, hi, cyc, n;
    logic [2:0] flags;
    x_ri  = !(ty == 1 || (ty == 4 && (md == 2 || md == 3)));
    x_cpu = !x_ri && !cp;
    x_ie  = !x_ri && !x_cpu && ty == 4 && md == 2 && idx >= NT;
    walk  = !(x_ri || x_cpu || x_ie);
    lo = 0; hi = NT - 1;
    if (ty == 4 && md == 2) begin
      if (idx < VS) hi = VS - 1;
      else begin lo = VS + ((idx - VS) / WY) * WY; hi = lo + WY - 1; end
    end
    if (coll == 1) begin ev[0] = 1; eg[0] = 8'h5A; end
    if (walk)
      for (int i = lo; i <= hi; i++)
        if (!ge || eg[i] == GW'(rg)) ev[i] = 0;
    if (coll == 2) begin ev[0] = 1; eg[0] = 8'h5A; end

    @(negedge clk);
    start = 1; cmd_index = IW'(idx); cmd_mmu_type = 3'(ty); cmd_walk_mode = 2'(md);
    cmd_gid_en = ge; cmd_root_gid = GW'(rg); cmd_cp_en = cp;
    @(negedge clk);
    start = 0; cmd_mmu_type = 3'd1; cmd_index = '0; cmd_cp_en = 1; cmd_walk_mode = 2'd3;
    cyc = 0; n = 0;
    while (!done && n < 200) begin
      if (busy) cyc++;
      fill_en = 0;
      start = 0;
      if (poke != 0 && cyc == 2) start = 1;
      if (coll != 0 && cyc == coll) begin
        fill_en = 1; fill_idx = '0; fill_valid = 1; fill_gid = 8'h5A;
      end
      n++;
      @(negedge clk);
    end
    fill_en = 0; start = 0;
    flags = {exc_cpu, exc_ri, idx_err};
    chk({req, " done seen"}, 64'(done), 64'd1);
    chk({req, " busy cycles R11"}, 64'(cyc), 64'(walk ? hi - lo + 1 : 0));
    chk({req, " flags"}, 64'(flags), 64'({x_cpu, x_ri, x_ie}));
    chk({req, " valid map"}, 64'(valid_map), 64'(model_map()));
    @(negedge clk);
    chk({req, " done one cycle R11"}, 64'({done, busy}), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset map", 64'(valid_map), 64'd0);
    chk("R1 reset outputs", 64'({busy, done, exc_cpu, exc_ri, idx_err}), 64'd0);
  endtask

  task automatic t_fill();
    load_all(0);
    chk("R2 fill all", 64'(valid_map), 64'(model_map()));
    @(negedge clk);
    fill_en = 1; fill_idx = IW'(7); fill_valid = 0; fill_gid = '0;
    @(negedge clk);
    fill_en = 0; ev[7] = 0;
    chk("R2 fill clears one", 64'(valid_map), 64'(model_map()));
    @(negedge clk);
    fill_en = 1; fill_idx = IW'(NT + 3); fill_valid = 1;
    @(negedge clk);
    fill_en = 0;
    chk("R2 fill out of range", 64'(valid_map), 64'(model_map()));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    load_all(1); run_cmd("R3 joint idx ignored", 33, 1, 2, 0, 0, 1);
    load_all(2); run_cmd("R4 variable region", 5, 4, 2, 0, 0, 1);
    load_all(3); run_cmd("R5 set 2", VS + 2 * WY + 1, 4, 2, 0, 0, 1);
    load_all(0); run_cmd("R5 last set", NT - 1, 4, 2, 0, 0, 1);
    load_all(1); run_cmd("R6 hardware walk", 20, 4, 3, 0, 0, 1);
    load_all(2); run_cmd("R7 gid filter joint", 0, 1, 2, 1, 2, 1);
    load_all(3); run_cmd("R7 gid filter set", VS + 4, 4, 2, 1, 1, 1);
    load_all(0); run_cmd("R8 cp disabled", 3, 4, 3, 0, 0, 0);
    run_cmd("R9 no tlb type", 3, 2, 2, 0, 0, 1);
    run_cmd("R9 bad mode", 3, 4, 1, 0, 0, 1);
    run_cmd("R9 over R8", 3, 0, 2, 0, 0, 0);
    run_cmd("R10 index too big", NT + 2, 4, 2, 0, 0, 1);
    load_all(1); run_cmd("R12 start while busy", 2, 4, 2, 0, 0, 1, 1);
    load_all(2); run_cmd("R13 fill at current entry", 0, 4, 3, 0, 0, 1, 0, 1);
    load_all(3); run_cmd("R13 fill behind walker", 0, 4, 3, 0, 0, 1, 0, 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule